// File: doc/BRIEF.md
# Dual Wiper Register Bank with Non-Volatile Shadowing

This block is the register file behind a serial front end that positions two digital potentiometer wipers. Each channel has a live 7-bit wiper register that drives the tap position, and a stored initial-value register that survives power loss. Five stored general-purpose bytes and one control register complete the map. The serial protocol engine sits outside the block. It drives a simple register port: address, write data, a write strobe, and a pulse when the bus transaction ends with a STOP. It reads through a combinational read-data output.

One control bit selects which copy addresses 0 and 1 reach. When that bit is clear, accesses go to the stored copy, and a write there also moves the live wiper. When it is set, only the live wipers are reachable and the general-purpose bytes are hidden. A stored write starts a timed commit at the next STOP. The commit is counted in clock cycles. While it runs, a busy flag is raised and every write is dropped.

At power-up both wipers sit at midscale until a power-good input is seen. They are then loaded from their stored values. The shutdown input is combined with a control bit to give a per-channel disconnect output. The register contents are kept through shutdown.

Top module: `potbank_regs`

## Requirements
- R1: After reset both wiper outputs are 40h, `busy` is 0, `chan_off` is 0 and the control register at address 8 reads 40h.
- R2: While `pwr_good` is low both wipers are held at 40h. In the cycle after `pwr_good` is first seen high, each wiper takes its stored initial value. A later low and high on `pwr_good` repeats this sequence.
- R3: With the select bit (control bit 7) set to 1, writes to address 0 or 1 change only the live wiper, and reads of addresses 0 and 1 return the live wiper. In this mode addresses 2..6 read 00h and writes to them are dropped. The stored copies are left unchanged.
- R4: With the select bit at 0, a write to address 0 or 1 updates both the stored value and the live wiper of that channel, and a read returns the stored value.
- R5: With the select bit at 0, addresses 2..6 hold five full 8-bit general-purpose bytes.
- R6: Address 7 and addresses 9..15 read 00h, and writes to them change no register.
- R7: The control register reads {select, shutdown-enable, busy, 5'b00000}. The busy bit (bit 5) and bits 4..0 cannot be written.
- R8: A STOP pulse that follows at least one write to a stored register raises `busy` on the next clock. `busy` stays high for exactly `NV_CYCLES` cycles. A STOP with no pending stored write leaves `busy` low.
- R9: While `busy` is 1, writes to every address are dropped.
- R10: `chan_off` is all ones when `shut_n` is low or control bit 6 is 0, and all zeros otherwise. Wiper values are kept through shutdown, remain readable and writable during it, and are presented unchanged when it ends.
- R11: Only 7 wiper bits are stored. Bit 7 of address 0 and address 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good | input | 1 | Supply is high enough for the stored values to be read |
| shut_n | input | 1 | Active-low shutdown pin |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| bus_stop | input | 1 | One-cycle pulse marking the end of a bus transaction |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| busy | output | 1 | Stored-value commit in progress |
| wiper_pos | output | NCH*WW | Live wiper positions, channel 0 in the low bits |
| chan_off | output | NCH | Per-channel disconnect (high end open, wiper tied low) |

## Verification
The hardest condition to reach from the ports is a write that arrives while a commit is still counting down. The bench shortens the commit to 12 cycles. After a stored write it pulses STOP, then issues a wiper write and a control write before the counter expires. Once `busy` falls, it reads both targets back. The second hard case is a power-good loss after new stored values have been committed. The bench drops and raises `pwr_good` late in the run, so the recall must return the rewritten values and not the reset defaults.

// File: rtl/pb_pkg.sv
package pb_pkg;
   // Control register bit positions (fixed by behaviour)
   localparam int CTL_SEL_BIT  = 7;
   localparam int CTL_SHDN_BIT = 6;
   localparam int CTL_BUSY_BIT = 5;

   typedef enum logic [1:0] {
      RG_WIPER = 2'd0,
      RG_GP    = 2'd1,
      RG_CTL   = 2'd2,
      RG_NONE  = 2'd3
   } region_e;
endpackage

// File: rtl/pb_commit_timer.sv
module pb_commit_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy <= 1'b0;
            else        busy <= start & ~busy;
         end
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else if (!busy) begin
               if (start) begin
                  busy <= 1'b1;
                  cnt  <= '0;
               end
            end else if (cnt == LAST) begin
               busy <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pb_wiper_slot.sv
module pb_wiper_slot #(
   parameter int WW = 7,
   parameter logic [WW-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_mid,
   input  logic          recall,
   input  logic          wr_live,
   input  logic          wr_nv,
   input  logic [WW-1:0] wdata,
   output logic [WW-1:0] live_q,
   output logic [WW-1:0] stored_q
);
   localparam logic [WW-1:0] MID = WW'(1) << (WW - 1);

   // Stored copy: reset models the factory content of the cell
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stored_q <= INIT;
      else if (wr_nv) stored_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 live_q <= MID;
      else if (hold_mid)          live_q <= MID;
      else if (recall)            live_q <= stored_q;
      else if (wr_live || wr_nv)  live_q <= wdata;
   end
endmodule

// File: rtl/potbank_regs.sv
module potbank_regs
   import pb_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int WW        = 7,
   parameter int NGP       = 5,
   parameter int DW        = 8,
   parameter int AW        = 4,
   parameter int NV_CYCLES = 240000,
   parameter logic [NCH*WW-1:0] IVR_INIT = {NCH{1'b1, {(WW-1){1'b0}}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              shut_n,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              reg_wr,
   input  logic              bus_stop,
   output logic [DW-1:0]     reg_rdata,
   output logic              busy,
   output logic [NCH*WW-1:0] wiper_pos,
   output logic [NCH-1:0]    chan_off
);
   localparam int GP_LO = NCH;
   localparam int GP_HI = NCH + NGP - 1;
   localparam int RSV_A = NCH + NGP;
   localparam int CTL_A = NCH + NGP + 1;
   localparam logic [AW-1:0] CTL_ADDR = AW'(CTL_A);

   // Elaboration-time parameter checks
   generate
      if (CTL_A >= (1 << AW)) begin : g_bad_aw
         $error("potbank_regs: AW too narrow for the register map");
      end
      if (WW >= DW) begin : g_bad_ww
         $error("potbank_regs: wiper width must be below data width");
      end
      if (DW <= CTL_SEL_BIT) begin : g_bad_dw
         $error("potbank_regs: data width too small for control bits");
      end
      if (NV_CYCLES < 1) begin : g_bad_nv
         $error("potbank_regs: NV_CYCLES must be at least 1");
      end
   endgenerate

   logic          sel_q, shdn_q, up_q, pend_q;
   logic          wr_ok, recall, hold_mid, nv_touch;
   logic [NCH-1:0] ch_live_we, ch_nv_we;
   logic [NGP-1:0] gp_we;
   logic [WW-1:0] live_a   [NCH];
   logic [WW-1:0] stored_a [NCH];
   logic [DW-1:0] gp_a     [NGP];
   region_e       region;

   assign wr_ok    = reg_wr & ~busy;
   assign hold_mid = ~pwr_good;
   assign recall   = pwr_good & ~up_q;

   always_comb begin
      if (int'(reg_addr) < NCH)                                 region = RG_WIPER;
      else if (int'(reg_addr) >= GP_LO && int'(reg_addr) <= GP_HI) region = RG_GP;
      else if (reg_addr == CTL_ADDR)                            region = RG_CTL;
      else                                                      region = RG_NONE;
   end

   // Per-channel wiper storage
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam logic [AW-1:0] MY_A = AW'(i);
         logic sel_me;
         assign sel_me        = wr_ok & (reg_addr == MY_A);
         assign ch_live_we[i] = sel_me & sel_q;
         assign ch_nv_we[i]   = sel_me & ~sel_q;

         pb_wiper_slot #(
            .WW   (WW),
            .INIT (IVR_INIT[i*WW +: WW])
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_mid (hold_mid),
            .recall   (recall),
            .wr_live  (ch_live_we[i]),
            .wr_nv    (ch_nv_we[i]),
            .wdata    (reg_wdata[WW-1:0]),
            .live_q   (live_a[i]),
            .stored_q (stored_a[i])
         );

         assign wiper_pos[i*WW +: WW] = live_a[i];
         assign chan_off[i]           = ~shut_n | ~shdn_q;
      end
   endgenerate

   // General-purpose stored bytes
   generate
      for (genvar j = 0; j < NGP; j++) begin : g_gp
         localparam logic [AW-1:0] MY_A = AW'(GP_LO + j);
         assign gp_we[j] = wr_ok & ~sel_q & (reg_addr == MY_A);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        gp_a[j] <= '0;
            else if (gp_we[j]) gp_a[j] <= reg_wdata;
         end
      end
   endgenerate

   assign nv_touch = (|ch_nv_we) | (|gp_we);

   // Control register, power-up tracker, pending commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         shdn_q <= 1'b1;
         up_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         up_q <= pwr_good;
         if (wr_ok && region == RG_CTL) begin
            sel_q  <= reg_wdata[CTL_SEL_BIT];
            shdn_q <= reg_wdata[CTL_SHDN_BIT];
         end
         if (bus_stop)      pend_q <= 1'b0;
         else if (nv_touch) pend_q <= 1'b1;
      end
   end

   pb_commit_timer #(.CYCLES(NV_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bus_stop & pend_q),
      .busy  (busy)
   );

   // Read path
   always_comb begin
      reg_rdata = '0;
      unique case (region)
         RG_WIPER: begin
            for (int i = 0; i < NCH; i++) begin
               if (reg_addr == AW'(i))
                  reg_rdata = {{(DW-WW){1'b0}}, (sel_q ? live_a[i] : stored_a[i])};
            end
         end
         RG_GP: begin
            for (int j = 0; j < NGP; j++) begin
               if (reg_addr == AW'(GP_LO + j) && !sel_q) reg_rdata = gp_a[j];
            end
         end
         RG_CTL: begin
            reg_rdata[CTL_SEL_BIT]  = sel_q;
            reg_rdata[CTL_SHDN_BIT] = shdn_q;
            reg_rdata[CTL_BUSY_BIT] = busy;
         end
         default: reg_rdata = '0;
      endcase
   end

   localparam int UNUSED_RSV = RSV_A;
endmodule

// File: rtl/potbank_regs_chk.sv
module potbank_regs_chk #(
   parameter int NCH       = 2,
   parameter int WW        = 7,
   parameter int NGP       = 5,
   parameter int DW        = 8,
   parameter int AW        = 4,
   parameter int NV_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_good,
   input logic              shut_n,
   input logic [AW-1:0]     reg_addr,
   input logic              bus_stop,
   input logic [DW-1:0]     reg_rdata,
   input logic              busy,
   input logic [NCH*WW-1:0] wiper_pos,
   input logic [NCH-1:0]    chan_off
);
   localparam logic [AW-1:0] RSV_ADDR = AW'(NCH + NGP);
   localparam logic [AW-1:0] CTL_ADDR = AW'(NCH + NGP + 1);
   localparam logic [AW-1:0] NCH_A    = AW'(NCH);
   localparam logic [WW-1:0] MID      = WW'(1) << (WW - 1);
   localparam logic [NCH*WW-1:0] MIDS = {NCH{MID}};

   // Busy-length window counted here, not unrolled
   logic [31:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1;
      else           run <= '0;
   end

   assert_mid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (wiper_pos == MIDS));

   assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_stop));

   assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == 32'(NV_CYCLES)));

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pwr_good && $past(pwr_good)) |=> $stable(wiper_pos));

   assert_pin_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !shut_n |-> (&chan_off));

   assert_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (shut_n && reg_addr == CTL_ADDR && reg_rdata[6]) |-> (chan_off == '0));

   assert_ctl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CTL_ADDR) |-> (reg_rdata[4:0] == '0 && reg_rdata[5] == busy));

   assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RSV_ADDR) |-> (reg_rdata == '0));

   assert_wiper_msb_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < NCH_A) |-> (reg_rdata[DW-1:WW] == '0));
endmodule

bind potbank_regs potbank_regs_chk #(
   .NCH(NCH), .WW(WW), .NGP(NGP), .DW(DW), .AW(AW), .NV_CYCLES(NV_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_good  (pwr_good),
   .shut_n    (shut_n),
   .reg_addr  (reg_addr),
   .bus_stop  (bus_stop),
   .reg_rdata (reg_rdata),
   .busy      (busy),
   .wiper_pos (wiper_pos),
   .chan_off  (chan_off)
);

// File: tb/potbank_regs_test.sv
`timescale 1ns/1ps
module potbank_regs_test;
   localparam int NV = 12;

   logic        clk = 1'b0;
   logic        rst_n, pwr_good, shut_n, reg_wr, bus_stop;
   logic [3:0]  reg_addr;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        busy;
   logic [13:0] wiper_pos;
   logic [1:0]  chan_off;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   potbank_regs #(
      .NV_CYCLES (NV),
      .IVR_INIT  ({7'h6A, 7'h15})
   ) uut (
      .clk, .rst_n, .pwr_good, .shut_n, .reg_addr, .reg_wdata, .reg_wr,
      .bus_stop, .reg_rdata, .busy, .wiper_pos, .chan_off
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = 4'(a);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic stop_pulse();
      @(negedge clk);
      bus_stop = 1'b1;
      @(negedge clk);
      bus_stop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      int cnt;
      rst_n = 1'b0; pwr_good = 1'b0; shut_n = 1'b1; reg_wr = 1'b0;
      bus_stop = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 wiper0", wiper_pos[6:0], 7'h40);
      chk("R1 wiper1", wiper_pos[13:7], 7'h40);
      chk("R1 busy", busy, 0);
      chk("R1 chan_off", chan_off, 0);
      rd(8, d); chk("R1 ctl", d, 8'h40);

      // R2 hold at midscale, then recall
      repeat (4) @(negedge clk);
      chk("R2 hold0", wiper_pos[6:0], 7'h40);
      chk("R2 hold1", wiper_pos[13:7], 7'h40);
      pwr_good = 1'b1;
      @(negedge clk);
      chk("R2 recall0", wiper_pos[6:0], 7'h15);
      chk("R2 recall1", wiper_pos[13:7], 7'h6A);

      // R4 / R11 stored write moves wiper too
      wr(0, 8'h93);
      chk("R4 live follows", wiper_pos[6:0], 7'h13);
      rd(0, d); chk("R11 msb clear", d, 8'h13);
      chk("R8 no busy before stop", busy, 0);

      // R8 / R9 commit blocks writes
      stop_pulse();
      chk("R8 busy raised", busy, 1);
      rd(8, d); chk("R7 busy bit", d, 8'h60);
      wr(1, 8'h22);
      wr(8, 8'h80);
      wait_idle();
      chk("R9 wiper1 kept", wiper_pos[13:7], 7'h6A);
      rd(1, d); chk("R9 stored1 kept", d, 8'h6A);
      rd(8, d); chk("R9 ctl kept", d, 8'h40);

      // R5 general-purpose sweep, R8 busy length
      for (int a = 2; a <= 6; a++) wr(a, 8'((a * 37 + 5) & 8'hFF));
      stop_pulse();
      cnt = 0;
      while (busy && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R8 busy length", cnt, NV);
      for (int a = 2; a <= 6; a++) begin
         rd(a, d); chk("R5 gp byte", d, (a * 37 + 5) & 8'hFF);
      end

      // R3 live-only mode
      wr(8, 8'hC0);
      rd(8, d); chk("R7 ctl sel", d, 8'hC0);
      wr(0, 8'h7F);
      chk("R3 live write", wiper_pos[6:0], 7'h7F);
      rd(0, d); chk("R3 live read", d, 8'h7F);
      stop_pulse();
      chk("R8 no commit", busy, 0);
      rd(3, d); chk("R3 gp hidden", d, 8'h00);
      wr(3, 8'hAA);
      wr(8, 8'h40);
      rd(0, d); chk("R3 stored untouched", d, 8'h13);
      rd(3, d); chk("R3 gp write dropped", d, (3 * 37 + 5) & 8'hFF);
      chk("R3 wiper0 kept", wiper_pos[6:0], 7'h7F);

      // R6 reserved and unmapped addresses
      wr(7, 8'hFF);
      for (int a = 9; a <= 15; a++) wr(a, 8'h5A);
      rd(7, d); chk("R6 addr7", d, 8'h00);
      for (int a = 9; a <= 15; a++) begin
         rd(a, d); chk("R6 unmapped", d, 8'h00);
      end
      for (int a = 2; a <= 6; a++) begin
         rd(a, d); chk("R6 gp intact", d, (a * 37 + 5) & 8'hFF);
      end
      rd(0, d); chk("R6 stored0", d, 8'h13);
      rd(1, d); chk("R6 stored1", d, 8'h6A);
      rd(8, d); chk("R6 ctl", d, 8'h40);
      chk("R6 busy", busy, 0);

      // R7 / R10 control-bit shutdown
      wr(8, 8'h3F);
      rd(8, d); chk("R7 ro bits", d, 8'h00);
      chk("R10 bit off", chan_off, 2'b11);
      chk("R10 kept0", wiper_pos[6:0], 7'h7F);
      wr(1, 8'h85);
      chk("R10 write in shutdown", wiper_pos[13:7], 7'h05);
      stop_pulse();
      wait_idle();
      wr(8, 8'h40);
      chk("R10 bit on", chan_off, 2'b00);
      chk("R10 restore1", wiper_pos[13:7], 7'h05);

      // R10 pin shutdown
      shut_n = 1'b0;
      @(negedge clk);
      chk("R10 pin off", chan_off, 2'b11);
      wr(8, 8'hC0);
      wr(0, 8'h21);
      chk("R10 live in shutdown", wiper_pos[6:0], 7'h21);
      shut_n = 1'b1;
      @(negedge clk);
      chk("R10 pin on", chan_off, 2'b00);
      chk("R10 restore0", wiper_pos[6:0], 7'h21);
      wr(8, 8'h40);

      // R2 second power cycle recalls committed values
      pwr_good = 1'b0;
      @(negedge clk);
      chk("R2 drop0", wiper_pos[6:0], 7'h40);
      chk("R2 drop1", wiper_pos[13:7], 7'h40);
      pwr_good = 1'b1;
      @(negedge clk);
      chk("R2 rerecall0", wiper_pos[6:0], 7'h13);
      chk("R2 rerecall1", wiper_pos[13:7], 7'h05);

      summary();
      $finish;
   end
endmodule